// File: doc/BRIEF.md
# Dual Event Performance Counter Unit

This block is a processor-side performance monitoring unit with two 32-bit event counters. Each counter selects one of sixteen event pulse inputs through a 4-bit selector held in a control register. Counting is allowed only when the global enable is set and the qualifier bit for the current processor privilege mode is set. Software reads and writes the unit through two plain 64-bit register ports. One is the control register. The other is a counter register that packs both counters side by side, so that one write reloads both counters at once.

A counter is treated as overflowed when its bit 31 is set. Software preloads `0x80000000 - N` so that the flag appears after N qualified events. While either flag is set and the global enable is on, the unit drives a registered level interrupt. Software clears the interrupt by rewriting the counter register with values whose bit 31 is clear. Every interface is a plain register or pin. There is no streaming data path, so the block has no valid/ready handshake and no back-pressure.

Top module: `dual_evt_perf_unit`

## Requirements
- R1: Control register bits [12:0] read back exactly as written on `ctrl_rd_data` from the cycle after the write. Bits [63:13] always read as zero.
- R2: Counter k (k = 0 or 1) increments only on a cycle where all three of the following hold:
  - control bit 4 (global enable) is 1;
  - `event_in[sel_k]` is 1, where sel_0 = control[8:5] and sel_1 = control[12:9];
  - the qualifier bit for `priv_mode` is 1. The encodings are 0 = exception level → bit 0, 1 = kernel → bit 1, 2 = supervisor → bit 2, 3 = user → bit 3.
- R3: `cnt_rd_data` holds counter 0 in bits [31:0] and counter 1 in bits [63:32]. A `cnt_wr_en` pulse loads both halves from `cnt_wr_data`, and the new values are visible the cycle after the write.
- R4: Each qualified cycle adds exactly one to the counter. The new value is visible on `cnt_rd_data` after that clock edge.
- R5: `irq` rises one cycle after either counter shows bit 31 = 1 while control bit 4 = 1. A preload of `0x80000000 - N` therefore sets bit 31 after N qualified events, and sets `irq` one cycle later.
- R6: Rewriting both counters with bit 31 clear drops `irq` one cycle after the new values appear.
- R7: After a write of zero to the control register, neither counter changes unless it is written, and `irq` is low from the following cycle.
- R8: A counter keeps counting past bit 31 and wraps from `0xFFFFFFFF` to zero.
- R9: When a counter write and a qualified event fall in the same cycle, the written value is loaded and the event is lost.
- R10: After reset, the control register and both counters read zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr_en | input | 1 | Write strobe for the control register |
| ctrl_wr_data | input | 64 | Control write value |
| ctrl_rd_data | output | 64 | Control register read value |
| cnt_wr_en | input | 1 | Write strobe for the packed counter register |
| cnt_wr_data | input | 64 | Packed counter write value {counter1, counter0} |
| cnt_rd_data | output | 64 | Packed counter read value {counter1, counter0} |
| priv_mode | input | 2 | Current privilege mode (0 exception, 1 kernel, 2 supervisor, 3 user) |
| event_in | input | 16 | Event pulses, one per event number |
| irq | output | 1 | Level overflow interrupt |

## Verification
A wrong selector slice or a wrong mode-bit decode shows up as a wrong count on `cnt_rd_data` right after the first edge where an event arrives under that setting. A wrong overflow or enable term in the interrupt path shows up on `irq` one edge after bit 31 changes, or after the enable changes. A bad priority between write and increment shows up as an off-by-one readback on the cycle after a write that collides with an event. The random phase keeps preloading values near the overflow and wrap points, so these faults surface within a few dozen cycles.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  parameter int CNT_W     = 32;
  parameter int NUM_CNT   = 2;
  parameter int NUM_EVT   = 16;
  parameter int SEL_W     = $clog2(NUM_EVT);
  parameter int NUM_MODE  = 4;
  parameter int MODE_W    = $clog2(NUM_MODE);
  parameter int REG_W     = 64;
  parameter int EN_BIT    = NUM_MODE;
  parameter int SEL_BASE  = EN_BIT + 1;
  parameter int CTRL_W    = SEL_BASE + NUM_CNT * SEL_W;
  parameter int FLAG_BIT  = CNT_W - 1;

  typedef enum logic [MODE_W-1:0] {
    MODE_EXC  = 2'd0,
    MODE_KERN = 2'd1,
    MODE_SUP  = 2'd2,
    MODE_USER = 2'd3
  } priv_mode_e;
endpackage

// File: rtl/pmu_ctrl_reg.sv
module pmu_ctrl_reg
  import pmu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [MODE_W-1:0] mode,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              glob_en,
  output logic              count_gate,
  output logic [REG_W-1:0]  rd_data
);
  logic unused_hi_bits;
  logic mode_ok;

  assign unused_hi_bits = ^wr_data[REG_W-1:CTRL_W];

  always_ff @(posedge clk) begin
    if (!rst_n)     ctrl_q <= '0;
    else if (wr_en) ctrl_q <= wr_data[CTRL_W-1:0];
  end

  always_comb begin
    mode_ok = 1'b0;
    for (int m = 0; m < NUM_MODE; m++)
      if (mode == MODE_W'(m)) mode_ok = ctrl_q[m];
  end

  assign glob_en    = ctrl_q[EN_BIT];
  assign count_gate = glob_en & mode_ok;
  assign rd_data    = {{(REG_W-CTRL_W){1'b0}}, ctrl_q};
endmodule

// File: rtl/pmu_event_counter.sv
module pmu_event_counter
  import pmu_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               gate,
  input  logic [SEL_W-1:0]   sel,
  input  logic [NUM_EVT-1:0] events,
  input  logic               wr_en,
  input  logic [CNT_W-1:0]   wr_val,
  output logic [CNT_W-1:0]   cnt
);
  logic hit;
  assign hit = gate & events[sel];

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (wr_en) cnt <= wr_val;
    else if (hit)   cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/pmu_irq_gen.sv
module pmu_irq_gen
  import pmu_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               glob_en,
  input  logic [NUM_CNT-1:0] flags,
  output logic               irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= glob_en & (|flags);
  end
endmodule

// File: rtl/dual_evt_perf_unit.sv
module dual_evt_perf_unit
  import pmu_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctrl_wr_en,
  input  logic [REG_W-1:0]   ctrl_wr_data,
  output logic [REG_W-1:0]   ctrl_rd_data,
  input  logic               cnt_wr_en,
  input  logic [REG_W-1:0]   cnt_wr_data,
  output logic [REG_W-1:0]   cnt_rd_data,
  input  logic [MODE_W-1:0]  priv_mode,
  input  logic [NUM_EVT-1:0] event_in,
  output logic               irq
);
  logic [CTRL_W-1:0]  ctrl_q;
  logic               glob_en;
  logic               count_gate;
  logic [NUM_CNT-1:0] flags;

  pmu_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(ctrl_wr_en), .wr_data(ctrl_wr_data),
    .mode(priv_mode), .ctrl_q(ctrl_q), .glob_en(glob_en),
    .count_gate(count_gate), .rd_data(ctrl_rd_data)
  );

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    logic [CNT_W-1:0] val;
    pmu_event_counter u_counter (
      .clk(clk), .rst_n(rst_n), .gate(count_gate),
      .sel(ctrl_q[SEL_BASE + k*SEL_W +: SEL_W]),
      .events(event_in), .wr_en(cnt_wr_en),
      .wr_val(cnt_wr_data[k*CNT_W +: CNT_W]), .cnt(val)
    );
    assign cnt_rd_data[k*CNT_W +: CNT_W] = val;
    assign flags[k] = val[FLAG_BIT];
  end

  pmu_irq_gen u_irq (
    .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .flags(flags), .irq(irq)
  );
endmodule

// File: rtl/pmu_checker.sv
module pmu_checker
  import pmu_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             ctrl_wr_en,
  input logic [REG_W-1:0] ctrl_wr_data,
  input logic [REG_W-1:0] ctrl_rd_data,
  input logic             cnt_wr_en,
  input logic [REG_W-1:0] cnt_wr_data,
  input logic [REG_W-1:0] cnt_rd_data,
  input logic             irq
);
  // R9
  wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_en |=> cnt_rd_data == $past(cnt_wr_data));
  // R1
  ctrl_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr_en |=> ctrl_rd_data == {{(REG_W-CTRL_W){1'b0}}, $past(ctrl_wr_data[CTRL_W-1:0])});
  // R5
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rd_data[EN_BIT] && (cnt_rd_data[FLAG_BIT] || cnt_rd_data[CNT_W+FLAG_BIT])) |=> irq);
  // R6
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl_rd_data[EN_BIT] && (cnt_rd_data[FLAG_BIT] || cnt_rd_data[CNT_W+FLAG_BIT])) |=> !irq);
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_rd_data[EN_BIT] && !cnt_wr_en) |=> $stable(cnt_rd_data));
  // R4
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr_en |=> (CNT_W'(cnt_rd_data[CNT_W-1:0] - $past(cnt_rd_data[CNT_W-1:0])) <= CNT_W'(1)));
endmodule

bind dual_evt_perf_unit pmu_checker u_pmu_checker (
  .clk(clk), .rst_n(rst_n), .ctrl_wr_en(ctrl_wr_en), .ctrl_wr_data(ctrl_wr_data),
  .ctrl_rd_data(ctrl_rd_data), .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
  .cnt_rd_data(cnt_rd_data), .irq(irq)
);

// File: tb/dual_evt_perf_unit_bench.sv
`timescale 1ns/1ps
module dual_evt_perf_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_wr_en = 1'b0;
  logic [63:0] ctrl_wr_data = '0;
  logic [63:0] ctrl_rd_data;
  logic        cnt_wr_en = 1'b0;
  logic [63:0] cnt_wr_data = '0;
  logic [63:0] cnt_rd_data;
  logic [1:0]  priv_mode = 2'd0;
  logic [15:0] event_in = '0;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [12:0] m_ctrl;
  logic [31:0] m_c0, m_c1;
  logic        m_irq;

  always #4 clk = ~clk;

  dual_evt_perf_unit u_dual_evt_perf_unit (
    .clk(clk), .rst_n(rst_n), .ctrl_wr_en(ctrl_wr_en), .ctrl_wr_data(ctrl_wr_data),
    .ctrl_rd_data(ctrl_rd_data), .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
    .cnt_rd_data(cnt_rd_data), .priv_mode(priv_mode), .event_in(event_in), .irq(irq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic qual(input logic [12:0] c, input logic [1:0] m, input logic [15:0] ev, input int k);
    logic [3:0] s;
    s = (k == 0) ? c[8:5] : c[12:9];
    return c[4] & c[m] & ev[s];
  endfunction

  task automatic model_edge();
    logic nirq;
    logic q0, q1;
    nirq = m_ctrl[4] & (m_c0[31] | m_c1[31]);
    q0 = qual(m_ctrl, priv_mode, event_in, 0);
    q1 = qual(m_ctrl, priv_mode, event_in, 1);
    if (cnt_wr_en) begin
      m_c0 = cnt_wr_data[31:0];
      m_c1 = cnt_wr_data[63:32];
    end else begin
      if (q0) m_c0 = m_c0 + 32'd1;
      if (q1) m_c1 = m_c1 + 32'd1;
    end
    if (ctrl_wr_en) m_ctrl = ctrl_wr_data[12:0];
    m_irq = nirq;
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("R1 ctrl readback", ctrl_rd_data, {51'd0, m_ctrl});
    chk("R4 counter value", cnt_rd_data, {m_c1, m_c0});
    chk("R5 irq level", {63'd0, irq}, {63'd0, m_irq});
  endtask

  task automatic idle_in();
    ctrl_wr_en = 1'b0; cnt_wr_en = 1'b0; event_in = '0;
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] snap;
    m_ctrl = '0; m_c0 = '0; m_c1 = '0; m_irq = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    chk("R10 ctrl after reset", ctrl_rd_data, 64'd0);
    chk("R10 counters after reset", cnt_rd_data, 64'd0);
    chk("R10 irq after reset", {63'd0, irq}, 64'd0);

    // R1 upper bits read zero
    ctrl_wr_en = 1'b1; ctrl_wr_data = '1;
    step(); idle_in();
    chk("R1 all-ones write", ctrl_rd_data, 64'h1FFF);

    // R5 preload 0x80000000-5, five user-mode events on event 3
    ctrl_wr_en = 1'b1; ctrl_wr_data = 64'(13'h10) | 64'(13'h08) | (64'd3 << 5) | (64'd5 << 9);
    step(); idle_in();
    cnt_wr_en = 1'b1; cnt_wr_data = {32'd0, 32'h8000_0000 - 32'd5};
    step(); idle_in();
    chk("R3 packed load", cnt_rd_data, {32'd0, 32'h7FFF_FFFB});
    priv_mode = 2'd3;
    for (int i = 0; i < 5; i++) begin
      event_in = 16'h0008;
      step();
    end
    idle_in();
    chk("R5 flag after N events", cnt_rd_data, {32'd0, 32'h8000_0000});
    chk("R5 irq not yet", {63'd0, irq}, 64'd0);
    step();
    chk("R5 irq raised", {63'd0, irq}, 64'd1);

    // R6 clear by rewrite
    cnt_wr_en = 1'b1; cnt_wr_data = 64'd0;
    step(); idle_in();
    chk("R6 irq held one cycle", {63'd0, irq}, 64'd1);
    step();
    chk("R6 irq cleared", {63'd0, irq}, 64'd0);

    // R2 kernel mode not enabled: no counting; event 5 counts on counter 1 in user mode
    priv_mode = 2'd1; event_in = 16'h0028;
    step(); step();
    chk("R2 kernel qualifier off", cnt_rd_data, 64'd0);
    priv_mode = 2'd3; event_in = 16'h0020;
    step();
    chk("R2 counter1 selector", cnt_rd_data, {32'd1, 32'd0});
    event_in = 16'h0000;

    // R9 write wins over event
    cnt_wr_en = 1'b1; cnt_wr_data = {32'd100, 32'd200}; event_in = 16'h0028;
    step(); idle_in();
    chk("R9 write beats event", cnt_rd_data, {32'd100, 32'd200});

    // R8 wrap at 2^32
    cnt_wr_en = 1'b1; cnt_wr_data = {32'hFFFF_FFFF, 32'hFFFF_FFFF};
    step(); idle_in();
    event_in = 16'h0028;
    step(); idle_in();
    chk("R8 wrap to zero", cnt_rd_data, 64'd0);

    // R7 zero control stops counting and irq
    cnt_wr_en = 1'b1; cnt_wr_data = {32'h8000_0000, 32'h9000_0000};
    step(); idle_in();
    ctrl_wr_en = 1'b1; ctrl_wr_data = 64'd0;
    step(); idle_in();
    snap = cnt_rd_data;
    event_in = '1;
    step(); step();
    chk("R7 counting stopped", cnt_rd_data, snap);
    chk("R7 irq low", {63'd0, irq}, 64'd0);
    idle_in();

    // random phase
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      ctrl_wr_en = (r < 4);
      ctrl_wr_data = {$urandom, $urandom};
      if ($urandom_range(0, 3) != 0) ctrl_wr_data[4] = 1'b1;
      cnt_wr_en = (r >= 90);
      case ($urandom_range(0, 3))
        0: cnt_wr_data = {32'h7FFF_FFFF - $urandom_range(0, 6), 32'h7FFF_FFFF - $urandom_range(0, 6)};
        1: cnt_wr_data = {32'hFFFF_FFFF - $urandom_range(0, 6), 32'h8000_0000 - $urandom_range(0, 6)};
        2: cnt_wr_data = 64'd0;
        default: cnt_wr_data = {$urandom, $urandom};
      endcase
      priv_mode = 2'($urandom_range(0, 3));
      event_in = 16'($urandom);
      step();
    end
    idle_in();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule